// File: doc/BRIEF.md
# Converter Command Byte Interpreter

This block sits behind the serial shift stage of a data converter's host port. Every byte that the shift stage assembles arrives on a one-cycle strobe. The block reads each byte as part of a small command language: single-byte control opcodes, continuous and one-shot data reads, calibration triggers, and two-byte register read and write headers followed by a data phase. Control opcodes become one-cycle pulses and mode flags for the converter core. Register traffic goes to a 32-entry, 8-bit register file held inside the block. Conversion results come from a parallel input word and leave on the same byte stream as register read-back.

The register file is a simple dual-port memory with no per-entry reset. After a reset, and after a reset opcode, a sweep rewrites every entry with its default value, one address per clock. Command bytes that arrive during the sweep, or in the cycle that starts it, are discarded. A single output sequencer produces the outgoing stream. A stream that has started always runs to its end, whatever the chip-select level does.

Top module: `adc_cmd_engine`

## Requirements
- R1: After reset, and once the 32-cycle default sweep has finished, every pulse, both mode flags and tx_valid are low. Every register at address a holds 8'hC0 | a.
- R2: The bytes 00h-01h, 02h-03h, 04h-05h and 06h-07h produce a one-cycle wake_pulse, standby_pulse, sync_pulse or reset_pulse respectively, and bit 0 has no effect. standby_mode is set by the standby opcode and cleared by the wake opcode.
- R3: Byte 10h sets cont_read_mode and byte 11h clears it. While the flag is set, each conv_ready strobe streams the CONV_BYTES bytes of conv_data, most significant byte first. While the flag is clear, conv_ready produces no output.
- R4: Byte 12h gives a read_once_pulse and streams one conversion result in the same byte order as R3.
- R5: Byte 60h gives offset_cal_pulse and byte 61h gives gain_cal_pulse.
- R6: The header 001aaaaa followed by a count byte xxxnnnnn streams nnnnn+1 register bytes. The addresses start at aaaaa and rise by one, wrapping from 31 to 0. The top three bits of the count byte have no effect.
- R7: The header 010aaaaa followed by a count byte xxxnnnnn stores the next nnnnn+1 received bytes at consecutive addresses starting at aaaaa, wrapping from 31 to 0.
- R8: Taking cs_n high discards any partly received command, so the next byte with cs_n low is decoded as a new opcode. Data bytes already stored stay stored. A byte strobed while cs_n is high has no effect.
- R9: A byte that matches no opcode causes no pulse, no flag change and no register write, and the next byte is decoded as a new opcode.
- R10: The reset opcode clears cont_read_mode and standby_mode and returns every register to its R1 default.
- R11: A stream request (a register read, a one-shot read or a continuous-mode conv_ready) that arrives while another stream is being output is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select level, active low |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| conv_ready | input | 1 | New-conversion event from the converter stub |
| conv_data | input | 8*CONV_BYTES | Latest conversion result |
| wake_pulse | output | 1 | Wake-up command pulse |
| standby_pulse | output | 1 | Standby command pulse |
| sync_pulse | output | 1 | Synchronize command pulse |
| reset_pulse | output | 1 | Reset command pulse |
| read_once_pulse | output | 1 | One-shot data read pulse |
| offset_cal_pulse | output | 1 | Offset calibration pulse |
| gain_cal_pulse | output | 1 | Gain calibration pulse |
| cont_read_mode | output | 1 | Continuous read mode flag |
| standby_mode | output | 1 | Standby mode flag |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_byte | output | 8 | Outgoing byte |

## Verification
The bench sends each of the 256 byte values as a lone command and checks every pulse, flag and stream against an arithmetic model. A decoder that honoured bit 0 of the control opcodes, or that acted on a bare register header, would fail that sweep. Register writes and reads also cover the 31-to-0 address wrap and a count byte with its top bits set. A design that failed to wrap would overwrite or return the wrong entries.

Chip select is raised in the middle of a register write. A decoder that kept its state would then treat the next opcode as data. The bench also fires conv_ready while a 32-byte register read is still being output. An arbiter that did not drop that request would splice conversion bytes into the read-back.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 5;
  localparam int REG_COUNT = 2 ** REG_AW;

  typedef enum logic [3:0] {
    OP_NONE, OP_WAKE, OP_STBY, OP_SYNC, OP_RST, OP_CONT_ON, OP_CONT_OFF,
    OP_READ_ONE, OP_REG_RD, OP_REG_WR, OP_OFS_CAL, OP_GAIN_CAL
  } op_e;

  typedef enum logic [1:0] {DEC_IDLE, DEC_COUNT, DEC_DATA} dec_state_e;

  // Map an opcode byte to its command class.
  function automatic op_e classify(input logic [BYTE_W-1:0] b);
    op_e r;
    r = OP_NONE;
    if (b[7:3] == 5'b00000) begin
      case (b[2:1])
        2'd0: r = OP_WAKE;
        2'd1: r = OP_STBY;
        2'd2: r = OP_SYNC;
        default: r = OP_RST;
      endcase
    end else if (b == 8'h10) r = OP_CONT_ON;
    else if (b == 8'h11) r = OP_CONT_OFF;
    else if (b == 8'h12) r = OP_READ_ONE;
    else if (b[7:5] == 3'b001) r = OP_REG_RD;
    else if (b[7:5] == 3'b010) r = OP_REG_WR;
    else if (b == 8'h60) r = OP_OFS_CAL;
    else if (b == 8'h61) r = OP_GAIN_CAL;
    return r;
  endfunction

  // Power-up content of a register entry.
  function automatic logic [BYTE_W-1:0] reg_default(input logic [REG_AW-1:0] a);
    return 8'hC0 | BYTE_W'(a);
  endfunction
endpackage

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
  import adc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              init_busy,
  output logic              wake_p,
  output logic              stby_p,
  output logic              sync_p,
  output logic              rst_p,
  output logic              rd1_p,
  output logic              ofs_p,
  output logic              gain_p,
  output logic              cont_mode,
  output logic              stby_mode,
  output logic              init_start,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_start,
  output logic [REG_AW-1:0] rd_addr,
  output logic [REG_AW:0]   rd_len
);
  dec_state_e        state;
  logic              is_write;
  logic [REG_AW-1:0] addr_q;
  logic [REG_AW:0]   left_q;
  logic              take;
  op_e               op;
  logic [REG_AW:0]   hdr_len;

  assign take    = rx_valid && !cs_n && !init_busy && !init_start;
  assign op      = classify(rx_byte);
  assign hdr_len = {1'b0, rx_byte[REG_AW-1:0]} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= DEC_IDLE;
      is_write   <= 1'b0;
      addr_q     <= '0;
      left_q     <= '0;
      wake_p     <= 1'b0;
      stby_p     <= 1'b0;
      sync_p     <= 1'b0;
      rst_p      <= 1'b0;
      rd1_p      <= 1'b0;
      ofs_p      <= 1'b0;
      gain_p     <= 1'b0;
      cont_mode  <= 1'b0;
      stby_mode  <= 1'b0;
      init_start <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      rd_start   <= 1'b0;
      rd_addr    <= '0;
      rd_len     <= '0;
    end else begin
      wake_p     <= 1'b0;
      stby_p     <= 1'b0;
      sync_p     <= 1'b0;
      rst_p      <= 1'b0;
      rd1_p      <= 1'b0;
      ofs_p      <= 1'b0;
      gain_p     <= 1'b0;
      init_start <= 1'b0;
      wr_en      <= 1'b0;
      rd_start   <= 1'b0;
      if (cs_n) begin
        state <= DEC_IDLE;
      end else if (take) begin
        case (state)
          DEC_IDLE: begin
            case (op)
              OP_WAKE:     begin wake_p <= 1'b1; stby_mode <= 1'b0; end
              OP_STBY:     begin stby_p <= 1'b1; stby_mode <= 1'b1; end
              OP_SYNC:     sync_p <= 1'b1;
              OP_RST: begin
                rst_p      <= 1'b1;
                cont_mode  <= 1'b0;
                stby_mode  <= 1'b0;
                init_start <= 1'b1;
              end
              OP_CONT_ON:  cont_mode <= 1'b1;
              OP_CONT_OFF: cont_mode <= 1'b0;
              OP_READ_ONE: rd1_p <= 1'b1;
              OP_OFS_CAL:  ofs_p <= 1'b1;
              OP_GAIN_CAL: gain_p <= 1'b1;
              OP_REG_RD, OP_REG_WR: begin
                is_write <= (op == OP_REG_WR);
                addr_q   <= rx_byte[REG_AW-1:0];
                state    <= DEC_COUNT;
              end
              default: ;
            endcase
          end
          DEC_COUNT: begin
            if (is_write) begin
              left_q <= hdr_len;
              state  <= DEC_DATA;
            end else begin
              rd_start <= 1'b1;
              rd_addr  <= addr_q;
              rd_len   <= hdr_len;
              state    <= DEC_IDLE;
            end
          end
          DEC_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= addr_q;
            wr_data <= rx_byte;
            addr_q  <= addr_q + 1'b1;
            left_q  <= left_q - 1'b1;
            if (left_q == 1) state <= DEC_IDLE;
          end
          default: state <= DEC_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_cmd_regfile.sv
module adc_cmd_regfile
  import adc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init_req,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_q,
  output logic              init_busy
);
  logic [BYTE_W-1:0] mem [REG_COUNT];
  logic [REG_AW-1:0] sweep_addr;
  logic              we;
  logic [REG_AW-1:0] wa;
  logic [BYTE_W-1:0] wd;

  // Sweep controller: one default write per cycle.
  always_ff @(posedge clk) begin
    if (rst || init_req) begin
      init_busy  <= 1'b1;
      sweep_addr <= '0;
    end else if (init_busy) begin
      sweep_addr <= sweep_addr + 1'b1;
      if (sweep_addr == REG_AW'(REG_COUNT - 1)) init_busy <= 1'b0;
    end
  end

  always_comb begin
    if (init_busy) begin
      we = 1'b1;
      wa = sweep_addr;
      wd = reg_default(sweep_addr);
    end else begin
      we = wr_en;
      wa = wr_addr;
      wd = wr_data;
    end
  end

  // Simple dual-port memory, no reset, registered read.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/adc_cmd_stream.sv
module adc_cmd_stream
  import adc_cmd_pkg::*;
#(
  parameter int CONV_BYTES = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_start,
  input  logic [REG_AW-1:0]            rd_base,
  input  logic [REG_AW:0]              rd_len,
  input  logic                         conv_go,
  input  logic [CONV_BYTES*BYTE_W-1:0] conv_data,
  input  logic [BYTE_W-1:0]            ram_q,
  output logic [REG_AW-1:0]            ram_addr,
  output logic                         tx_valid,
  output logic [BYTE_W-1:0]            tx_byte
);
  localparam int CONV_W = CONV_BYTES * BYTE_W;
  localparam int MAXLEN = (REG_COUNT > CONV_BYTES) ? REG_COUNT : CONV_BYTES;
  localparam int LEN_W  = $clog2(MAXLEN + 1);

  logic              active;
  logic              src_conv;
  logic [REG_AW-1:0] ptr;
  logic [LEN_W-1:0]  left;
  logic [CONV_W-1:0] conv_sh;
  logic              s1_v;
  logic              s1_conv;
  logic [BYTE_W-1:0] s1_cb;

  assign ram_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      src_conv <= 1'b0;
      ptr      <= '0;
      left     <= '0;
      conv_sh  <= '0;
      s1_v     <= 1'b0;
      s1_conv  <= 1'b0;
      s1_cb    <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      s1_v <= 1'b0;
      if (!active) begin
        if (rd_start) begin
          active   <= 1'b1;
          src_conv <= 1'b0;
          ptr      <= rd_base;
          left     <= LEN_W'(rd_len);
        end else if (conv_go) begin
          active   <= 1'b1;
          src_conv <= 1'b1;
          conv_sh  <= conv_data;
          left     <= LEN_W'(CONV_BYTES);
        end
      end else begin
        s1_v    <= 1'b1;
        s1_conv <= src_conv;
        s1_cb   <= conv_sh[CONV_W-1 -: BYTE_W];
        conv_sh <= conv_sh << BYTE_W;
        ptr     <= ptr + 1'b1;
        left    <= left - 1'b1;
        if (left == 1) active <= 1'b0;
      end
      // Align with the memory's registered read.
      tx_valid <= s1_v;
      tx_byte  <= s1_conv ? s1_cb : ram_q;
    end
  end
endmodule

// File: rtl/adc_cmd_engine.sv
module adc_cmd_engine
  import adc_cmd_pkg::*;
#(
  parameter int CONV_BYTES = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cs_n,
  input  logic                         rx_valid,
  input  logic [7:0]                   rx_byte,
  input  logic                         conv_ready,
  input  logic [CONV_BYTES*8-1:0]      conv_data,
  output logic                         wake_pulse,
  output logic                         standby_pulse,
  output logic                         sync_pulse,
  output logic                         reset_pulse,
  output logic                         read_once_pulse,
  output logic                         offset_cal_pulse,
  output logic                         gain_cal_pulse,
  output logic                         cont_read_mode,
  output logic                         standby_mode,
  output logic                         tx_valid,
  output logic [7:0]                   tx_byte
);
  logic              init_busy;
  logic              init_start;
  logic              wr_en;
  logic [REG_AW-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic              rd_start;
  logic [REG_AW-1:0] rd_addr;
  logic [REG_AW:0]   rd_len;
  logic [REG_AW-1:0] ram_addr;
  logic [BYTE_W-1:0] ram_q;
  logic              conv_go;

  assign conv_go = read_once_pulse | (conv_ready & cont_read_mode);

  adc_cmd_decode u_dec (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .init_busy  (init_busy),
    .wake_p     (wake_pulse),
    .stby_p     (standby_pulse),
    .sync_p     (sync_pulse),
    .rst_p      (reset_pulse),
    .rd1_p      (read_once_pulse),
    .ofs_p      (offset_cal_pulse),
    .gain_p     (gain_cal_pulse),
    .cont_mode  (cont_read_mode),
    .stby_mode  (standby_mode),
    .init_start (init_start),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_start   (rd_start),
    .rd_addr    (rd_addr),
    .rd_len     (rd_len)
  );

  adc_cmd_regfile u_rf (
    .clk       (clk),
    .rst       (rst),
    .init_req  (init_start),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (ram_addr),
    .rd_q      (ram_q),
    .init_busy (init_busy)
  );

  adc_cmd_stream #(.CONV_BYTES(CONV_BYTES)) u_str (
    .clk       (clk),
    .rst       (rst),
    .rd_start  (rd_start),
    .rd_base   (rd_addr),
    .rd_len    (rd_len),
    .conv_go   (conv_go),
    .conv_data (conv_data),
    .ram_q     (ram_q),
    .ram_addr  (ram_addr),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte)
  );
endmodule

// File: rtl/adc_cmd_engine_chk.sv
module adc_cmd_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       wake_pulse,
  input logic       standby_pulse,
  input logic       sync_pulse,
  input logic       reset_pulse,
  input logic       read_once_pulse,
  input logic       offset_cal_pulse,
  input logic       gain_cal_pulse,
  input logic       cont_read_mode,
  input logic       standby_mode
);
  logic [6:0] pulses;
  assign pulses = {wake_pulse, standby_pulse, sync_pulse, reset_pulse,
                   read_once_pulse, offset_cal_pulse, gain_cal_pulse};

  assert_pulse_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulses));

  assert_standby_entry_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(standby_mode) |-> standby_pulse);

  assert_cont_entry_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(cont_read_mode) |-> $past(rx_valid && !cs_n && rx_byte == 8'h10));

  assert_cont_exit_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cont_read_mode) |->
      $past(rx_valid && !cs_n && (rx_byte == 8'h11 || rx_byte[7:1] == 7'b0000011)));

  assert_cs_high_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cs_n) |=> (pulses == 7'd0));

  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
    reset_pulse |-> (!cont_read_mode && !standby_mode));
endmodule

bind adc_cmd_engine adc_cmd_engine_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .cs_n             (cs_n),
  .rx_valid         (rx_valid),
  .rx_byte          (rx_byte),
  .wake_pulse       (wake_pulse),
  .standby_pulse    (standby_pulse),
  .sync_pulse       (sync_pulse),
  .reset_pulse      (reset_pulse),
  .read_once_pulse  (read_once_pulse),
  .offset_cal_pulse (offset_cal_pulse),
  .gain_cal_pulse   (gain_cal_pulse),
  .cont_read_mode   (cont_read_mode),
  .standby_mode     (standby_mode)
);

// File: tb/tb_adc_cmd_engine.sv
module tb_adc_cmd_engine;
  localparam int CB = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = 8'h00;
  logic          conv_ready = 1'b0;
  logic [CB*8-1:0] conv_data = 24'h123456;
  logic wake_pulse, standby_pulse, sync_pulse, reset_pulse, read_once_pulse;
  logic offset_cal_pulse, gain_cal_pulse, cont_read_mode, standby_mode, tx_valid;
  logic [7:0] tx_byte;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [7:0] mem_m [32];
  bit cont_m = 1'b0;
  bit stby_m = 1'b0;
  logic [7:0] txq [$];
  logic [7:0] expq [$];

  adc_cmd_engine #(.CONV_BYTES(CB)) dut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) if (tx_valid) txq.push_back(tx_byte);

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs(bit lvl);
    @(negedge clk);
    cs_n = lvl;
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_conv();
    @(negedge clk);
    conv_ready = 1'b1;
    @(negedge clk);
    conv_ready = 1'b0;
  endtask

  function automatic logic [6:0] pulses_now();
    return {wake_pulse, standby_pulse, sync_pulse, reset_pulse,
            read_once_pulse, offset_cal_pulse, gain_cal_pulse};
  endfunction

  function automatic logic [6:0] exp_pulses(logic [7:0] b);
    if (b[7:1] == 7'd0) return 7'b1000000;
    if (b[7:1] == 7'd1) return 7'b0100000;
    if (b[7:1] == 7'd2) return 7'b0010000;
    if (b[7:1] == 7'd3) return 7'b0001000;
    if (b == 8'h12)     return 7'b0000100;
    if (b == 8'h60)     return 7'b0000010;
    if (b == 8'h61)     return 7'b0000001;
    return 7'd0;
  endfunction

  task automatic model_defaults();
    for (int a = 0; a < 32; a++) mem_m[a] = 8'hC0 | 8'(a);
  endtask

  task automatic push_conv();
    for (int k = CB - 1; k >= 0; k--) expq.push_back(conv_data[k*8 +: 8]);
  endtask

  task automatic check_stream(string req);
    chk({req, " stream length"}, txq.size(), expq.size());
    for (int i = 0; i < expq.size() && i < txq.size(); i++)
      chk({req, " stream byte"}, txq[i], expq[i]);
    txq.delete();
    expq.delete();
  endtask

  task automatic check_flags(string req);
    chk({req, " cont_read_mode"}, cont_read_mode, cont_m);
    chk({req, " standby_mode"}, standby_mode, stby_m);
  endtask

  task automatic reg_read(string req, int a, logic [7:0] cnt);
    int n;
    n = int'(cnt[4:0]) + 1;
    cs(1'b0);
    send(8'h20 | 8'(a));
    send(cnt);
    cs(1'b1);
    idle(n + 8);
    for (int i = 0; i < n; i++) expq.push_back(mem_m[(a + i) % 32]);
    check_stream(req);
  endtask

  task automatic reg_write(int a, logic [7:0] cnt, int seed);
    int n;
    n = int'(cnt[4:0]) + 1;
    cs(1'b0);
    send(8'h40 | 8'(a));
    send(cnt);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'((seed * 7 + i * 13 + a) & 8'hFF);
      send(d);
      mem_m[(a + i) % 32] = d;
    end
    cs(1'b1);
    idle(2);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    idle(40);
    model_defaults();
    // R1: quiet outputs and default registers
    chk("R1 pulses", pulses_now(), 0);
    check_flags("R1");
    chk("R1 tx_valid", tx_valid, 0);
    reg_read("R1 R6 defaults", 0, 8'd31);

    // R2 R4 R5 R9: every byte value as a lone command
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      bb = 8'(b);
      cs(1'b0);
      send(bb);
      chk($sformatf("R2 R4 R5 R9 pulses for %02h", bb), pulses_now(), exp_pulses(bb));
      if (bb[7:1] == 7'd0) stby_m = 1'b0;
      if (bb[7:1] == 7'd1) stby_m = 1'b1;
      if (bb[7:1] == 7'd3) begin cont_m = 1'b0; stby_m = 1'b0; end
      if (bb == 8'h10) cont_m = 1'b1;
      if (bb == 8'h11) cont_m = 1'b0;
      if (bb == 8'h12) push_conv();
      check_flags($sformatf("R2 R3 flags for %02h", bb));
      cs(1'b1);
      idle(bb[7:1] == 7'd3 ? 40 : 8);
      check_stream($sformatf("R4 R9 stream for %02h", bb));
    end
    reg_read("R9 registers untouched", 0, 8'd31);

    // R9: decoder ready right after an undefined byte
    cs(1'b0);
    send(8'hFF);
    send(8'h04);
    chk("R9 sync after junk", pulses_now(), 7'b0010000);
    cs(1'b1);

    // R7 R6: writes including wrap and full file
    reg_write(0, 8'd0, 1);
    reg_write(5, 8'd3, 2);
    reg_write(30, 8'd3, 3);
    reg_read("R7 wrap readback", 28, 8'd7);
    reg_write(0, 8'd31, 4);
    reg_write(9, 8'hE2, 5);
    reg_read("R6 R7 count top bits ignored", 9, 8'hA3);
    reg_read("R6 R7 full readback", 17, 8'd31);

    // R8: abort in header and in data phase
    cs(1'b0);
    send(8'h45);
    cs(1'b1);
    cs(1'b0);
    send(8'h04);
    chk("R8 fresh opcode after header abort", pulses_now(), 7'b0010000);
    cs(1'b1);
    cs(1'b0);
    send(8'h4A);
    send(8'd3);
    send(8'h5A); mem_m[10] = 8'h5A;
    send(8'hA5); mem_m[11] = 8'hA5;
    cs(1'b1);
    cs(1'b0);
    send(8'h60);
    chk("R8 fresh opcode after data abort", pulses_now(), 7'b0000010);
    cs(1'b1);
    reg_read("R8 partial write kept", 8, 8'd7);
    cs_n = 1'b1;
    send(8'h04);
    chk("R8 byte with cs high", pulses_now(), 0);
    send(8'h10);
    idle(2);
    check_flags("R8 cs high no mode");

    // R3: continuous read
    conv_data = 24'hA1B2C3;
    pulse_conv();
    idle(8);
    check_stream("R3 conv_ready ignored when off");
    cs(1'b0);
    send(8'h10);
    cs(1'b1);
    cont_m = 1'b1;
    check_flags("R3 enter");
    pulse_conv(); push_conv();
    idle(8);
    conv_data = 24'h0F1E2D;
    pulse_conv(); push_conv();
    idle(8);
    check_stream("R3 continuous streams");

    // R11: conv request during a register stream is dropped
    cs(1'b0);
    send(8'h20);
    send(8'd31);
    cs(1'b1);
    idle(3);
    pulse_conv();
    idle(45);
    for (int i = 0; i < 32; i++) expq.push_back(mem_m[i]);
    check_stream("R11 overlapping request dropped");

    cs(1'b0);
    send(8'h11);
    cs(1'b1);
    cont_m = 1'b0;
    check_flags("R3 exit");
    pulse_conv();
    idle(8);
    check_stream("R3 conv_ready ignored after stop");

    // R10: reset opcode restores defaults and clears modes
    cs(1'b0);
    send(8'h10);
    send(8'h03);
    cs(1'b1);
    cont_m = 1'b1;
    stby_m = 1'b1;
    check_flags("R10 before reset");
    cs(1'b0);
    send(8'h07);
    chk("R10 reset pulse", pulses_now(), 7'b0001000);
    cs(1'b1);
    cont_m = 1'b0;
    stby_m = 1'b0;
    check_flags("R10 after reset");
    idle(40);
    model_defaults();
    reg_read("R10 defaults restored", 3, 8'd31);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule